// File: doc/BRIEF.md
# Pulse Span Timer

This block measures the time between edges on a single pulse input. A 16-bit counter runs freely at a rate set by a power-of-two prescaler. On each qualifying edge of the synchronised input, the counter value is latched into a capture register.

A small wrap counter records how many times the main counter rolled over since the previous capture. From this count and the two capture values, the block forms a 24-bit interval that stays correct across several rollovers. A one-bit sticky flag could not do this, because it cannot tell one rollover from two.

Software can still use the classic view: a sticky overflow flag with a clear input, an overflow interrupt pulse and a capture interrupt pulse.

Top module: `pulse_span_timer`

## Requirements
- R1: While `cnt_en` is 1 the counter advances by one on every prescaler tick and rolls from FFFFh to 0000h. While `cnt_en` is 0 the counter is 0000h from the next clock edge on.
- R2: `div_sel` = s gives one tick every 2^s clock cycles (s = 0..7). The prescaler restarts when counting is enabled, so the counter reads n after n·2^s edges.
- R3: `ovf_irq_o` is high for exactly one cycle, in the cycle in which `count_o` first reads 0000h after a rollover.
- R4: `ovf_flag_o` becomes 1 with every rollover and stays 1 until `ovf_clr` is high at a clock edge. A rollover at the same edge as a clear leaves the flag at 1.
- R5: `pulse_in` passes through two synchroniser flops. `edge_sel` picks the capturing edges: 00 none, 01 rising, 10 falling, 11 both. The capture registers at the third clock edge after the input changes. No capture occurs while `cnt_en` is 0.
- R6: A capture loads `capture_o` with the counter value as updated at that capture edge, so `capture_o` equals `count_o` in the cycle `cap_irq_o` is high. `cap_irq_o` is a one-cycle pulse per capture.
- R7: With each capture, `width_o` = wraps·2^16 + new capture − previous capture (mod 2^24), and `width_valid_o` pulses with `cap_irq_o`. "wraps" is the number of rollovers in the interval. The first capture after enabling measures from a previous value of 0.
- R8: A rollover in the same cycle as a capture belongs to the interval that capture closes. That capture reads 0000h, and the next interval starts with zero wraps.
- R9: The wrap count saturates at its all-ones value. If a further rollover arrives while it is saturated, `range_err_o` is 1 with that interval's result; otherwise it is 0. It is updated on every capture.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable; 0 stops and clears the counter |
| div_sel | input | 3 | Prescaler select, divide by 2^div_sel |
| edge_sel | input | 2 | Capture edge mode |
| pulse_in | input | 1 | Asynchronous pulse to measure |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| count_o | output | 16 | Current counter value |
| capture_o | output | 16 | Last captured counter value |
| ovf_flag_o | output | 1 | Sticky rollover flag |
| ovf_irq_o | output | 1 | One-cycle rollover pulse |
| cap_irq_o | output | 1 | One-cycle capture pulse |
| width_o | output | 24 | Extended interval of the last capture |
| width_valid_o | output | 1 | Strobe for a new `width_o` |
| range_err_o | output | 1 | Interval exceeded the wrap count range |

## Verification
The assertions assume `cnt_en`, `div_sel` and `ovf_clr` are driven to known values from the first clock edge. The increment property also relies on `div_sel` holding still while it is zero. The stimulus changes control inputs only between clock edges and always from reset-time defaults. It also spaces pulse edges at least several cycles apart, so each capture can be matched to its own strobe. Random intervals and prescaler settings are drawn from a seeded generator. Directed cases place a capture exactly on a rollover and span two rollovers. A small second instance, with a 4-bit counter and 2-bit wrap count, reaches saturation within a short run.

// File: rtl/pst_pkg.sv
package pst_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    function automatic logic edge_hit(edge_mode_e mode, logic rise, logic fall);
        logic hit;
        case (mode)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_ANY:  hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pst_prescaler.sv
module pst_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);

    localparam int PRE_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } presc_st_t;

    presc_st_t        st_d, st_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        st_d   = st_q;
        mask   = ~({PRE_W{1'b1}} << div_sel);
        tick   = en && ((st_q.pre & mask) == mask);
        st_d.pre = en ? st_q.pre + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pst_timebase.sv
module pst_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             wrap_o,
    output logic             ovf_flag_o,
    output logic             ovf_irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             irq;
    } tb_st_t;

    tb_st_t st_d, st_q;
    logic   wrap;

    always_comb begin
        st_d = st_q;
        wrap = en && tick && (st_q.cnt == {CNT_W{1'b1}});
        if (!en)       st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + 1'b1;
        if (wrap)         st_d.flag = 1'b1;
        else if (ovf_clr) st_d.flag = 1'b0;
        st_d.irq = wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o      = st_q.cnt;
    assign cnt_next_o = st_d.cnt;
    assign wrap_o     = wrap;
    assign ovf_flag_o = st_q.flag;
    assign ovf_irq_o  = st_q.irq;

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !ovf_clr) |=> st_q.flag);                          // R4
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.cnt == '0 && st_q.flag));                     // R3

endmodule

// File: rtl/pst_edge_detect.sv
module pst_edge_detect #(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       pulse_in,
    input  logic [1:0] edge_sel,
    output logic       cap_ev_o
);
    import pst_pkg::*;

    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev;
    } ed_st_t;

    ed_st_t st_d, st_q;
    logic   rise, fall, lvl;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_N-2:0], pulse_in};
        lvl       = st_q.sync[SYNC_N-1];
        st_d.prev = lvl;
        rise      = lvl & ~st_q.prev;
        fall      = ~lvl & st_q.prev;
        cap_ev_o  = en && edge_hit(edge_mode_e'(edge_sel), rise, fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pst_capture.sv
module pst_capture #(
    parameter int CNT_W  = 16,
    parameter int WRAP_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    cap_ev,
    input  logic                    wrap,
    input  logic [CNT_W-1:0]        cnt_next,
    output logic [CNT_W-1:0]        capture_o,
    output logic [CNT_W+WRAP_W-1:0] width_o,
    output logic                    width_valid_o,
    output logic                    cap_irq_o,
    output logic                    range_err_o
);

    localparam int WID_W = CNT_W + WRAP_W;

    typedef struct packed {
        logic [CNT_W-1:0]  prev;
        logic [WRAP_W-1:0] wc;
        logic              sat;
        logic [CNT_W-1:0]  cap;
        logic [WID_W-1:0]  width;
        logic              valid;
        logic              irq;
        logic              rerr;
    } cap_st_t;

    cap_st_t           st_d, st_q;
    logic [WRAP_W-1:0] wc_eff;
    logic              wc_full, sat_eff;
    logic [WID_W-1:0]  span;

    always_comb begin
        st_d    = st_q;
        wc_full = (st_q.wc == {WRAP_W{1'b1}});
        wc_eff  = (wrap && !wc_full) ? st_q.wc + 1'b1 : st_q.wc;
        sat_eff = st_q.sat | (wrap & wc_full);
        span    = {wc_eff, {CNT_W{1'b0}}} + WID_W'(cnt_next) - WID_W'(st_q.prev);
        st_d.valid = 1'b0;
        st_d.irq   = 1'b0;
        if (!en) begin
            st_d.prev = '0;
            st_d.wc   = '0;
            st_d.sat  = 1'b0;
        end else if (cap_ev) begin
            st_d.cap   = cnt_next;
            st_d.prev  = cnt_next;
            st_d.width = span;
            st_d.rerr  = sat_eff;
            st_d.wc    = '0;
            st_d.sat   = 1'b0;
            st_d.valid = 1'b1;
            st_d.irq   = 1'b1;
        end else begin
            st_d.wc  = wc_eff;
            st_d.sat = sat_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign capture_o     = st_q.cap;
    assign width_o       = st_q.width;
    assign width_valid_o = st_q.valid;
    assign cap_irq_o     = st_q.irq;
    assign range_err_o   = st_q.rerr;

    AST_COINCIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cap_ev && wrap) |=> (st_q.cap == '0 && st_q.wc == '0));   // R8

endmodule

// File: rtl/pulse_span_timer.sv
module pulse_span_timer #(
    parameter int CNT_W  = 16,
    parameter int WRAP_W = 8,
    parameter int SEL_W  = 3,
    parameter int SYNC_N = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cnt_en,
    input  logic [SEL_W-1:0]        div_sel,
    input  logic [1:0]              edge_sel,
    input  logic                    pulse_in,
    input  logic                    ovf_clr,
    output logic [CNT_W-1:0]        count_o,
    output logic [CNT_W-1:0]        capture_o,
    output logic                    ovf_flag_o,
    output logic                    ovf_irq_o,
    output logic                    cap_irq_o,
    output logic [CNT_W+WRAP_W-1:0] width_o,
    output logic                    width_valid_o,
    output logic                    range_err_o
);

    logic             tick, wrap, cap_ev;
    logic [CNT_W-1:0] cnt_next;

    pst_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .div_sel(div_sel), .tick(tick)
    );

    pst_timebase #(.CNT_W(CNT_W)) u_tbase (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .tick(tick), .ovf_clr(ovf_clr),
        .cnt_o(count_o), .cnt_next_o(cnt_next), .wrap_o(wrap),
        .ovf_flag_o(ovf_flag_o), .ovf_irq_o(ovf_irq_o)
    );

    pst_edge_detect #(.SYNC_N(SYNC_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .pulse_in(pulse_in),
        .edge_sel(edge_sel), .cap_ev_o(cap_ev)
    );

    pst_capture #(.CNT_W(CNT_W), .WRAP_W(WRAP_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .cap_ev(cap_ev), .wrap(wrap),
        .cnt_next(cnt_next), .capture_o(capture_o), .width_o(width_o),
        .width_valid_o(width_valid_o), .cap_irq_o(cap_irq_o),
        .range_err_o(range_err_o)
    );

    AST_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> (count_o == '0));                                    // R1
    AST_DIV1_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_en) && $past(div_sel) == '0 && cnt_en)
            |-> count_o == $past(count_o) + 1'b1);                       // R2
    AST_NO_CAP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> !cap_irq_o);                                         // R5
    AST_CAP_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq_o |-> (capture_o == count_o && width_valid_o));          // R6

endmodule

// File: tb/pulse_span_timer_bench.sv
module pulse_span_timer_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        cnt_en, pulse, ovf_clr;
    logic [2:0]  div_sel;
    logic [1:0]  edge_sel;
    logic [15:0] count_o, capture_o;
    logic        ovf_flag_o, ovf_irq_o, cap_irq_o, width_valid_o, range_err_o;
    logic [23:0] width_o;

    pulse_span_timer u_pulse_span_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .div_sel(div_sel),
        .edge_sel(edge_sel), .pulse_in(pulse), .ovf_clr(ovf_clr),
        .count_o(count_o), .capture_o(capture_o), .ovf_flag_o(ovf_flag_o),
        .ovf_irq_o(ovf_irq_o), .cap_irq_o(cap_irq_o), .width_o(width_o),
        .width_valid_o(width_valid_o), .range_err_o(range_err_o)
    );

    logic       s_en, s_pulse;
    logic [3:0] s_cnt, s_cap;
    logic       s_flag, s_oirq, s_cirq, s_valid, s_rerr;
    logic [5:0] s_width;

    pulse_span_timer #(.CNT_W(4), .WRAP_W(2)) u_pulse_span_timer_sat (
        .clk(clk), .rst_n(rst_n), .cnt_en(s_en), .div_sel(3'd0),
        .edge_sel(2'b11), .pulse_in(s_pulse), .ovf_clr(1'b0),
        .count_o(s_cnt), .capture_o(s_cap), .ovf_flag_o(s_flag),
        .ovf_irq_o(s_oirq), .cap_irq_o(s_cirq), .width_o(s_width),
        .width_valid_o(s_valid), .range_err_o(s_rerr)
    );

    int     checks = 0;
    int     fails  = 0;
    bit     done   = 1'b0;
    longint cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int          n_str = 0, n_ovf = 0, s_n = 0;
    logic [23:0] last_w;
    longint      last_cyc = 0, prev_cyc = 0;
    logic [5:0]  s_last_w;
    logic        s_last_rerr;

    always @(negedge clk) if (rst_n) begin
        if (width_valid_o) begin
            n_str++;
            prev_cyc = last_cyc;
            last_cyc = cyc;
            last_w   = width_o;
            chk(cap_irq_o == 1'b1, "R6 cap_irq with strobe", cap_irq_o, 1);
            chk(capture_o == count_o, "R6 capture equals count", capture_o, count_o);
        end
        if (ovf_irq_o) begin
            n_ovf++;
            chk(count_o == 16'h0, "R3 irq at zero", count_o, 0);
        end
        if (s_valid) begin
            s_n++;
            s_last_w    = s_width;
            s_last_rerr = s_rerr;
        end
    end

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic longint expect_width(input longint ticks);
        return ticks % (64'd1 << 24);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base, prev_d, sel, r, n0;
        void'($urandom(32'd20240611));
        cnt_en = 0; div_sel = 0; edge_sel = 0; pulse = 0; ovf_clr = 0;
        s_en = 0; s_pulse = 0;
        wn(3);
        chk(count_o == 0 && capture_o == 0 && width_o == 0, "R10 reset values", count_o, 0);
        chk(!ovf_flag_o && !ovf_irq_o && !cap_irq_o && !width_valid_o && !range_err_o,
            "R10 reset flags", ovf_flag_o, 0);
        rst_n = 1;
        wn(2);

        // R9 saturation on the small instance
        s_en = 1; wn(2);
        s_pulse = 1; wn(4);
        chk(s_n == 1, "R5 small first capture", s_n, 1);
        wn(36); s_pulse = 0; wn(4);
        chk(s_last_w == 6'd40, "R7 two-wrap width small", s_last_w, 40);
        chk(s_last_rerr == 0, "R9 no range error", s_last_rerr, 0);
        wn(76); s_pulse = 1; wn(4);
        chk(s_n == 3 && s_last_rerr == 1, "R9 range error set", s_last_rerr, 1);
        wn(16); s_pulse = 0; wn(4);
        chk(s_last_rerr == 0, "R9 range error cleared", s_last_rerr, 0);
        chk(s_last_w == 6'd20, "R9 width after recovery", s_last_w, 20);

        // R1 counting and hold
        cnt_en = 1; wn(50);
        chk(count_o == 16'd50, "R1 counts each cycle", count_o, 50);
        cnt_en = 0; wn(2);
        chk(count_o == 0, "R1 cleared when disabled", count_o, 0);
        wn(5);
        chk(count_o == 0, "R1 held when disabled", count_o, 0);

        // R5 no capture while disabled
        edge_sel = 2'b01; base = n_str;
        pulse = 1; wn(6);
        chk(n_str == base, "R5 no capture disabled", n_str, base);
        pulse = 0; wn(6);

        // R7 random rising-edge intervals
        cnt_en = 1; wn(3);
        prev_d = 0;
        for (int i = 0; i < 10; i++) begin
            int d, hi;
            d  = 40 + int'($urandom % 960);
            hi = 5 + int'($urandom % (d - 10));
            base = n_str;
            pulse = 1; wn(4);
            chk(n_str == base + 1, "R5 rising capture", n_str, base + 1);
            if (i > 0) chk(last_w == expect_width(prev_d), "R7 random width", last_w, prev_d);
            wn(hi - 4); pulse = 0; wn(d - hi);
            prev_d = d;
        end

        // R5 falling only
        edge_sel = 2'b10; base = n_str;
        pulse = 1; wn(6);
        chk(n_str == base, "R5 rising ignored in falling mode", n_str, base);
        wn(10); pulse = 0; wn(4);
        chk(n_str == base + 1, "R5 falling capture", n_str, base + 1);
        wn(30); pulse = 1; wn(10); pulse = 0; wn(4);
        chk(last_w == 24'd44, "R7 falling width", last_w, 44);

        // R5 none
        edge_sel = 2'b00; base = n_str;
        pulse = 1; wn(10); pulse = 0; wn(10);
        chk(n_str == base, "R5 no capture in off mode", n_str, base);

        // R5 both edges
        edge_sel = 2'b11; base = n_str;
        pulse = 1; wn(4);
        chk(n_str == base + 1, "R5 both-edge capture", n_str, base + 1);
        wn(21); pulse = 0; wn(4);
        chk(n_str == base + 2 && last_w == 24'd25, "R7 both-edge width", last_w, 25);

        // R2 prescaler
        for (int i = 0; i < 5; i++) begin
            sel = 1 + int'($urandom % 7);
            r   = 3 + int'($urandom % 8);
            cnt_en = 0; wn(2);
            div_sel = 3'(sel); cnt_en = 1;
            wn(4 << sel);
            chk(count_o == 16'd4, "R2 prescaled count", count_o, 4);
            pulse = ~pulse; wn(r << sel);
            pulse = ~pulse; wn(4);
            chk(last_w == 24'(r), "R2 prescaled width", last_w, r);
        end

        // R4 and R8 long interval with two rollovers
        cnt_en = 0; wn(2);
        div_sel = 0; edge_sel = 2'b01; pulse = 0; wn(2);
        cnt_en = 1;
        n0 = n_ovf;
        while (count_o !== 16'hFFF0) @(negedge clk);
        pulse = 1; wn(4);
        chk(capture_o == 16'hFFF3, "R6 capture before rollover", capture_o, 16'hFFF3);
        base = n_str;
        while (n_ovf == n0) @(negedge clk);
        chk(ovf_flag_o == 1, "R4 flag set on rollover", ovf_flag_o, 1);
        pulse = 0; wn(10);
        chk(ovf_flag_o == 1, "R4 flag sticky", ovf_flag_o, 1);
        ovf_clr = 1; wn(1); ovf_clr = 0;
        chk(ovf_flag_o == 0, "R4 flag cleared", ovf_flag_o, 0);
        while (count_o !== 16'hFFFD) @(negedge clk);
        pulse = 1; wn(2);
        ovf_clr = 1; wn(1); ovf_clr = 0;
        #1;
        chk(width_valid_o == 1 && ovf_irq_o == 1, "R8 capture with rollover", width_valid_o, 1);
        chk(capture_o == 16'h0, "R8 coincident capture value", capture_o, 0);
        chk(width_o == 24'h1000D, "R8 width counts both wraps", width_o, 24'h1000D);
        chk(longint'(width_o) == expect_width(last_cyc - prev_cyc), "R7 width vs elapsed cycles",
            width_o, last_cyc - prev_cyc);
        chk(ovf_flag_o == 1, "R4 rollover beats clear", ovf_flag_o, 1);
        chk(n_str == base + 1, "R8 single strobe", n_str, base + 1);
        wn(47); pulse = 0; wn(50); pulse = 1; wn(4);
        chk(last_w == 24'd100, "R8 next interval restarts", last_w, 100);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule